// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides an unsigned dividend by an unsigned divisor of the same width. It returns a quotient and a remainder. It works bit-serially and forms one quotient bit per clock. All of the working state lives in one double-width shift register. The partial remainder sits in the upper half. The dividend bits sit in the lower half, and quotient bits fill that half from the bottom as the dividend bits move out.

A division begins when a start pulse arrives while the block is idle.

1. The operands are captured. The register is aligned one place to the left.
2. Each step subtracts the divisor from the upper half as a trial.
3. If the trial borrows, the old upper half is kept, which restores it. Otherwise the difference replaces it.
4. The register then shifts left by one, and the new low bit is the quotient bit.
5. After the last step, one right shift of the upper half alone removes the excess left shift.

When the division ends, the remainder is presented on the high result port and the quotient on the low result port. A one-cycle done pulse marks the result. A zero divisor gives no division. The block instead raises a divide-by-zero flag together with done in the next cycle, and the result values are then meaningless.

Top module: `seq_divider`

## Requirements
- R1: After a synchronous reset, busy, done and the divide-by-zero flag are 0, and both the quotient and the remainder read 0.
- R2: For a nonzero divisor, the quotient and remainder satisfy dividend = divisor * quotient + remainder.
- R3: For a nonzero divisor, the remainder is strictly less than the divisor.
- R4: A start sampled while idle with a nonzero divisor sets busy from the next cycle. Done rises W+3 clock edges after that start edge (35 for W = 32), and done is never high while busy is high.
- R5: Done lasts exactly one cycle. Quotient and remainder hold their values until the next accepted start.
- R6: A start with a zero divisor sets done and the divide-by-zero flag in the next cycle, and busy is never raised. The flag stays set until the next accepted start, which clears it when that start carries a nonzero divisor.
- R7: A start pulse while busy is ignored. The running division completes with the operands captured at its own start.
- R8: Results are exact when the partial remainder needs W+1 bits, as when the divisor has its top bit set (0xFFFFFFFF / 0x80000001 gives quotient 1, remainder 0x7FFFFFFE).
- R9: 73 divided by 5 gives quotient 14 and remainder 3.
- R10: A divisor larger than the dividend gives quotient 0 and the dividend as remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled when idle |
| dividend_i | input | W | Unsigned dividend |
| divisor_i | input | W | Unsigned divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result strobe |
| div_zero_o | output | 1 | Last accepted start had a zero divisor |
| remainder_o | output | W | Remainder (high half of the working register) |
| quotient_o | output | W | Quotient (low half of the working register) |

## Verification
The hardest case to reach is a trial subtraction on a partial remainder whose bit W is set. This only arises when the divisor is above half the range and the dividend has enough high ones. The stimulus therefore picks operands such as all-ones over 0x80000001, and a divisor equal to the top bit alone. A start pulse injected halfway through a running division with different operands checks that capture happens only at the accepted start. A zero-divisor request followed by a normal division checks that the flag sets and then clears.

// File: rtl/seq_div_pkg.sv
package seq_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_STEP  = 2'd2,
    ST_FIX   = 2'd3
  } div_state_e;
endpackage

// File: rtl/div_trial_sub.sv
// Trial subtraction of the divisor from a (W+1)-bit partial remainder.
// The partial remainder is always below twice the divisor, so a W+1 bit
// result is enough: its top bit is the borrow, its low W bits the difference.
module div_trial_sub #(
  parameter int W = 32
) (
  input  logic [W:0]   part_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] diff_o,
  output logic         borrow_o
);
  logic [W:0] wide;

  assign wide     = part_i - {1'b0, dvs_i};
  assign borrow_o = wide[W];
  assign diff_o   = wide[W-1:0];
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import seq_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic zero_dvs_i,
  output logic load_o,
  output logic align_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o,
  output logic done_o,
  output logic dz_o
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

  div_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign accept  = start_i && (state_q == ST_IDLE);
  assign load_o  = accept;
  assign align_o = (state_q == ST_ALIGN);
  assign step_o  = (state_q == ST_STEP);
  assign fix_o   = (state_q == ST_FIX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE:  if (accept && !zero_dvs_i) state_q <= ST_ALIGN;
        ST_ALIGN: begin
          state_q <= ST_STEP;
          cnt_q   <= '0;
        end
        ST_STEP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_STEP) state_q <= ST_FIX;
        end
        ST_FIX:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      dz_o   <= 1'b0;
    end else begin
      done_o <= fix_o || (accept && zero_dvs_i);
      if (accept) begin
        busy_o <= !zero_dvs_i;
        dz_o   <= zero_dvs_i;
      end else if (fix_o) begin
        busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/div_datapath.sv
// Combined remainder/quotient register: hi_q holds the partial remainder
// with one guard bit, lo_q holds dividend bits that are being replaced by
// quotient bits.
module div_datapath #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         align_i,
  input  logic         step_i,
  input  logic         fix_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] remainder_o,
  output logic [W-1:0] quotient_o
);
  logic [W:0]   hi_q;
  logic [W-1:0] lo_q;
  logic [W-1:0] dvs_q;
  logic [W-1:0] diff;
  logic         borrow;
  logic [W-1:0] kept;

  div_trial_sub #(.W(W)) u_trial (
    .part_i   (hi_q),
    .dvs_i    (dvs_q),
    .diff_o   (diff),
    .borrow_o (borrow)
  );

  // Restore by selection: on a borrow the old partial remainder survives.
  assign kept = borrow ? hi_q[W-1:0] : diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      hi_q  <= '0;
      lo_q  <= dividend_i;
      dvs_q <= divisor_i;
    end else if (align_i) begin
      hi_q  <= {hi_q[W-1:0], lo_q[W-1]};
      lo_q  <= {lo_q[W-2:0], 1'b0};
    end else if (step_i) begin
      hi_q  <= {kept, lo_q[W-1]};
      lo_q  <= {lo_q[W-2:0], ~borrow};
    end else if (fix_i) begin
      hi_q  <= {1'b0, hi_q[W:1]};
    end
  end

  assign remainder_o = hi_q[W-1:0];
  assign quotient_o  = lo_q;
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         div_zero_o,
  output logic [W-1:0] remainder_o,
  output logic [W-1:0] quotient_o
);
  logic load, align, step, fix;
  logic zero_dvs;

  assign zero_dvs = (divisor_i == '0);

  div_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .zero_dvs_i (zero_dvs),
    .load_o     (load),
    .align_o    (align),
    .step_o     (step),
    .fix_o      (fix),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .dz_o       (div_zero_o)
  );

  div_datapath #(.W(W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load),
    .align_i     (align),
    .step_i      (step),
    .fix_i       (fix),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .remainder_o (remainder_o),
    .quotient_o  (quotient_o)
  );
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         div_zero_o,
  input logic [W-1:0] remainder_o,
  input logic [W-1:0] quotient_o
);
  logic [W-1:0] cap_dvd, cap_dvs;
  logic [15:0]  lat;
  logic         acc;

  assign acc = start_i && !busy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_dvd <= '0;
      cap_dvs <= '0;
      lat     <= '0;
    end else if (acc) begin
      cap_dvd <= dividend_i;
      cap_dvs <= divisor_i;
      lat     <= 16'd1;
    end else if (busy_o) begin
      lat <= lat + 16'd1;
    end
  end

  // R2 and R7: identity against operands captured at the accepted start
  p_identity_r2: assert property (@(posedge clk) disable iff (rst)
    (done_o && !div_zero_o) |->
      ({{W{1'b0}}, quotient_o} * {{W{1'b0}}, cap_dvs} + {{W{1'b0}}, remainder_o})
        == {{W{1'b0}}, cap_dvd});

  p_rem_below_r3: assert property (@(posedge clk) disable iff (rst)
    (done_o && !div_zero_o) |-> (remainder_o < cap_dvs));

  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    (done_o && !div_zero_o) |-> (lat == 16'(W + 3)));

  p_busy_done_excl_r4: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !done_o);

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && (divisor_i == '0)) |=> (done_o && div_zero_o && !busy_o));
endmodule

bind seq_divider seq_divider_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .dividend_i  (dividend_i),
  .divisor_i   (divisor_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .div_zero_o  (div_zero_o),
  .remainder_o (remainder_o),
  .quotient_o  (quotient_o)
);

// File: tb/test_seq_divider.sv
module test_seq_divider;
  localparam int W          = 32;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY    = W + 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic         busy_o, done_o, div_zero_o;
  logic [W-1:0] remainder_o, quotient_o;

  int checks = 0;
  int errors = 0;

  seq_divider #(.W(W)) i_seq_divider (
    .clk(clk), .rst(rst), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .div_zero_o(div_zero_o),
    .remainder_o(remainder_o), .quotient_o(quotient_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Pulse start for one cycle, then count negedges until done.
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b,
                        output int lat, output logic first_busy);
    @(negedge clk);
    start_i = 1'b1; dividend_i = a; divisor_i = b;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    first_busy = busy_o;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset;
    check(busy_o == 1'b0, "R1 busy", busy_o, 0);
    check(done_o == 1'b0, "R1 done", done_o, 0);
    check(div_zero_o == 1'b0, "R1 div_zero", div_zero_o, 0);
    check(quotient_o == '0 && remainder_o == '0, "R1 results", {quotient_o, remainder_o}, 0);
  endtask

  task automatic t_divide(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    int lat; logic fb;
    logic [W-1:0] eq, er;
    eq = a / b; er = a % b;
    launch(a, b, lat, fb);
    check(fb == 1'b1, {tag, " R4 busy after start"}, fb, 1);
    check(lat == LATENCY, {tag, " R4 latency"}, lat, LATENCY);
    check(quotient_o == eq, {tag, " R2 quotient"}, quotient_o, eq);
    check(remainder_o == er, {tag, " R2 remainder"}, remainder_o, er);
    check(remainder_o < b, {tag, " R3 remainder below divisor"}, remainder_o, b);
    check(div_zero_o == 1'b0, {tag, " R6 flag clear"}, div_zero_o, 0);
    @(negedge clk);
    check(done_o == 1'b0, {tag, " R5 done single cycle"}, done_o, 0);
    @(negedge clk);
    check(quotient_o == eq && remainder_o == er, {tag, " R5 hold"}, {quotient_o, remainder_o}, {eq, er});
  endtask

  task automatic t_example_r9;
    int lat; logic fb;
    launch(32'd73, 32'd5, lat, fb);
    check(quotient_o == 32'd14, "R9 quotient 73/5", quotient_o, 14);
    check(remainder_o == 32'd3, "R9 remainder 73/5", remainder_o, 3);
  endtask

  task automatic t_wide_partial_r8;
    int lat; logic fb;
    launch(32'hFFFF_FFFF, 32'h8000_0001, lat, fb);
    check(quotient_o == 32'd1, "R8 quotient", quotient_o, 1);
    check(remainder_o == 32'h7FFF_FFFE, "R8 remainder", remainder_o, 32'h7FFF_FFFE);
    t_divide(32'hFFFF_FFFF, 32'h8000_0000, "R8 top-bit divisor");
  endtask

  task automatic t_small_dividend_r10;
    int lat; logic fb;
    launch(32'h1234_5678, 32'hFFFF_FFFF, lat, fb);
    check(quotient_o == '0, "R10 quotient zero", quotient_o, 0);
    check(remainder_o == 32'h1234_5678, "R10 remainder is dividend", remainder_o, 32'h1234_5678);
  endtask

  task automatic t_zero_r6;
    int lat; logic fb;
    launch(32'd99, 32'd0, lat, fb);
    check(lat == 1, "R6 done next cycle", lat, 1);
    check(div_zero_o == 1'b1, "R6 flag set", div_zero_o, 1);
    check(fb == 1'b0, "R6 no busy", fb, 0);
    @(negedge clk);
    check(div_zero_o == 1'b1 && done_o == 1'b0, "R6 flag held, done dropped", {div_zero_o, done_o}, 2'b10);
  endtask

  task automatic t_start_while_busy_r7;
    int lat;
    @(negedge clk);
    start_i = 1'b1; dividend_i = 32'd1000; divisor_i = 32'd10;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    repeat (4) begin @(negedge clk); lat++; end
    start_i = 1'b1; dividend_i = 32'd7; divisor_i = 32'd3;
    @(negedge clk); lat++;
    start_i = 1'b0; dividend_i = '0; divisor_i = '0;
    while (!done_o && lat < 200) begin @(negedge clk); lat++; end
    check(lat == LATENCY, "R7 latency from first start", lat, LATENCY);
    check(quotient_o == 32'd100 && remainder_o == 32'd0, "R7 first operands kept",
          {quotient_o, remainder_o}, {32'd100, 32'd0});
    check(div_zero_o == 1'b0, "R7 no flag", div_zero_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_example_r9();
    t_divide(32'd100, 32'd7, "basic");
    t_divide(32'hFFFF_FFFF, 32'd1, "unit divisor");
    t_divide(32'hDEAD_BEEF, 32'h0001_2345, "mixed");
    t_wide_partial_r8();
    t_small_dividend_r10();
    t_zero_r6();
    t_divide(32'h8000_0000, 32'h8000_0000, "equal after zero");
    t_start_while_busy_r7();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule